// File: doc/BRIEF.md
# Fast-Page DRAM Module Controller

This block turns single-word host requests into the strobe sequences of a 36-bit asynchronous DRAM module that has two physical sides. Row and column share one 10-bit address bus. Each side is selected by a pair of row strobes, and each of the four 9-bit byte lanes has its own column strobe. One write-enable line serves the whole module.

A host presents one request at a time. The request carries the operation, a side, a row, a column, a lane mask and write data. The controller raises a one-cycle done pulse when the access ends, and for a read it returns the captured word with the unselected lanes cleared. Data in and data out share the same module pins, so every write is an early write. The controller also runs a CAS-before-RAS refresh of both sides on a fixed interval, and that refresh takes priority over new host traffic.

All timing values are parameters in nanoseconds. They are rounded up to whole clocks at elaboration, and the default clock period is 10 ns.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, all row strobes and all column strobes are high, write enable is high, done is low and the write-data drive is off. Once reset is released, the request port is ready.
- R2: For an access, the row is on the address bus when the row strobes fall and the column is on the bus when the column strobes fall. Data written to a given side, row and column reads back from that same location.
- R3: Row strobe bit i drives row strobe i. An access to side 0 pulls only strobes 0 and 2 low (pattern 4'b1010). An access to side 1 pulls only strobes 1 and 3 low (pattern 4'b0101). Only a refresh pulls all four low.
- R4: Lane i is data bits [9i+8:9i] and has column strobe bit i. Only the lanes set in the request mask, which must be nonzero, are strobed. A write changes only those lanes. Read data returns zero in the lanes that were not selected.
- R5: Every write is an early write. Write enable is already low in the cycle before the column strobes fall and stays unchanged while any column strobe is low. The data drive is on only during write accesses.
- R6: During a read, write enable is high before and during the column strobe. Read data is captured no earlier than the column access time rounded up to clocks, plus one clock, after the column strobes fall.
- R7: The strobes meet the minimum timings: row precharge 40 ns, row low 60 ns, row-to-column delay 15 ns, column low 15 ns and random cycle 110 ns.
- R8: A refresh lowers all four column strobes at least 5 ns before all four row strobes fall. It keeps them low for at least 10 ns after that, with write enable high.
- R9: A refresh starts every 15.6 us, which is 1560 clocks at 10 ns. A refresh can be late by at most the remainder of an access already in progress.
- R10: A due refresh wins over a new host request, and the host port is not ready while a refresh is pending or running. A refresh never interrupts an access already in progress.
- R11: Done is a single-cycle pulse. It comes 2 + tRCD clocks + CAS-window clocks after the clock edge that accepts the request. The CAS window is the largest of three values: tCAS in clocks, tCAC in clocks plus 1, and tRAS minus tRCD minus 1, also in clocks. With the defaults the pulse comes 7 clocks after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request is accepted on an edge where valid and ready are both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_side | input | 1 | Module side to access |
| req_lanes | input | 4 | Byte-lane mask (nonzero) |
| req_row | input | 10 | Row address |
| req_col | input | 10 | Column address |
| req_wdata | input | 36 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 36 | Read data, with unselected lanes zeroed |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 4 | Row strobes, active low |
| dram_cas_n | output | 4 | Column strobes per lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 36 | Data driven toward the module |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 36 | Data returned by the module |

## Verification
The done pulse and its read data are due exactly 7 clocks after the accepting edge. The bench counts falling edges from that edge and checks both the latency and the data on the falling edge where done first appears. A behavioural module model samples the strobes on every falling edge, halfway between the controller's update edges, and measures each strobe interval in whole clocks. The model returns garbage until the column access time has passed since the column strobe fell, so a capture that comes too early shows up as wrong read data. The refresh interval is checked each time all four row strobes fall, against the clock count since the previous refresh.

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int CLK_NS    = 10,
  parameter int ADDR_W    = 10,
  parameter int LANES     = 4,
  parameter int LANE_W    = 9,
  parameter int T_RC_NS   = 110,
  parameter int T_RAS_NS  = 60,
  parameter int T_RP_NS   = 40,
  parameter int T_RCD_NS  = 15,
  parameter int T_CAS_NS  = 15,
  parameter int T_CAC_NS  = 15,
  parameter int T_CSR_NS  = 5,
  parameter int T_CHR_NS  = 10,
  parameter int T_REFI_NS = 15600
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic                    req_side,
  input  logic [LANES-1:0]        req_lanes,
  input  logic [ADDR_W-1:0]       req_row,
  input  logic [ADDR_W-1:0]       req_col,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  output logic                    rsp_done,
  output logic [LANES*LANE_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0]       dram_addr,
  output logic [3:0]              dram_ras_n,
  output logic [LANES-1:0]        dram_cas_n,
  output logic                    dram_we_n,
  output logic [LANES*LANE_W-1:0] dram_dq_out,
  output logic                    dram_dq_oe,
  input  logic [LANES*LANE_W-1:0] dram_dq_in
);

  localparam int DW = LANES * LANE_W;

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RC_C   = to_cyc(T_RC_NS);
  localparam int RAS_C  = to_cyc(T_RAS_NS);
  localparam int RP_C   = to_cyc(T_RP_NS);
  localparam int RCD_C  = to_cyc(T_RCD_NS);
  localparam int CAS_C  = to_cyc(T_CAS_NS);
  localparam int CAC_C  = to_cyc(T_CAC_NS);
  localparam int CSR_C  = to_cyc(T_CSR_NS);
  localparam int CHR_C  = to_cyc(T_CHR_NS);
  localparam int REFI_C = to_cyc(T_REFI_NS);
  localparam int WIN_C  = max2(max2(CAS_C, CAC_C + 1), RAS_C - RCD_C - 1);
  localparam int ALO_C  = RCD_C + 1 + WIN_C;
  localparam int APRE_C = max2(RP_C, RC_C - ALO_C);
  localparam int RLO_C  = max2(RAS_C, CHR_C);
  localparam int RPRE_C = max2(RP_C, RC_C - RLO_C);
  localparam int CW     = $clog2(RC_C + ALO_C + RLO_C + 2);
  localparam int RW     = $clog2(REFI_C + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_RCD, S_COL, S_CAS, S_PRE, S_RCAS, S_RRAS
  } st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [RW-1:0]     ref_ctr;
  logic              ref_pend;
  logic              l_wr, l_side;
  logic [LANES-1:0]  l_lanes;
  logic [ADDR_W-1:0] l_row, l_col;
  logic [DW-1:0]     l_wdata;
  logic [DW-1:0]     lane_bits;
  logic [CW-1:0]     hi_cnt;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_bits[i*LANE_W +: LANE_W] = {LANE_W{l_lanes[i]}};
  end

  wire in_row = (st == S_ROW) || (st == S_RCD);
  wire in_col = (st == S_COL) || (st == S_CAS);
  wire in_ref = (st == S_RCAS) || (st == S_RRAS);
  wire [3:0] side_low = l_side ? 4'b1010 : 4'b0101;

  assign req_ready   = (st == S_IDLE) && !ref_pend;
  assign dram_ras_n  = (st == S_RRAS) ? 4'h0 : ((st == S_RCD || in_col) ? ~side_low : 4'hF);
  assign dram_cas_n  = in_ref ? '0 : ((st == S_CAS) ? ~l_lanes : '1);
  assign dram_we_n   = !(l_wr && in_col);
  assign dram_dq_oe  = l_wr && in_col;
  assign dram_dq_out = l_wdata;
  assign dram_addr   = in_row ? l_row : (in_col ? l_col : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ref_ctr <= '0; ref_pend <= 1'b0;
      l_wr <= 1'b0; l_side <= 1'b0; l_lanes <= '0; l_row <= '0; l_col <= '0;
      l_wdata <= '0; rsp_done <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (ref_pend) begin
            ref_pend <= 1'b0;
            st <= S_RCAS; cnt <= CW'(CSR_C - 1);
          end else if (req_valid) begin
            l_wr <= req_write; l_side <= req_side; l_lanes <= req_lanes;
            l_row <= req_row; l_col <= req_col; l_wdata <= req_wdata;
            st <= S_ROW;
          end
        end
        S_ROW: begin st <= S_RCD; cnt <= CW'(RCD_C - 1); end
        S_COL: begin st <= S_CAS; cnt <= CW'(WIN_C - 1); end
        default: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            case (st)
              S_RCD:  st <= S_COL;
              S_CAS: begin
                st <= S_PRE; cnt <= CW'(APRE_C - 1); rsp_done <= 1'b1;
                if (!l_wr) rsp_rdata <= dram_dq_in & lane_bits;
              end
              S_RCAS: begin st <= S_RRAS; cnt <= CW'(RLO_C - 1); end
              S_RRAS: begin st <= S_PRE; cnt <= CW'(RPRE_C - 1); end
              default: st <= S_IDLE;
            endcase
          end
        end
      endcase
      if (ref_ctr == RW'(REFI_C - 1)) begin
        ref_ctr <= '0; ref_pend <= 1'b1;
      end else ref_ctr <= ref_ctr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= CW'(RP_C);
    else if (dram_ras_n != 4'hF) hi_cnt <= '0;
    else if (hi_cnt < CW'(RP_C)) hi_cnt <= hi_cnt + 1'b1;
  end

  // R3
  ras_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dram_ras_n inside {4'hF, 4'b1010, 4'b0101, 4'h0});

  // R5
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_we_n && dram_cas_n != '1 && $past(dram_cas_n) == '1) |-> !$past(dram_we_n));

  // R5
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cas_n != '1 && $past(dram_cas_n) != '1) |-> $stable(dram_we_n));

  // R6
  read_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cas_n != '1 && !dram_dq_oe) |-> dram_we_n);

  // R8
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_ras_n == 4'h0 && $past(dram_ras_n) == 4'hF) |-> ($past(dram_cas_n) == '0));

  // R7
  ras_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_ras_n != 4'hF && $past(dram_ras_n) == 4'hF) |-> (hi_cnt >= CW'(RP_C)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

endmodule

// File: tb/fpm_dram_ctrl_tb.sv
module fpm_dram_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_RC = 110, T_RAS = 60, T_RP = 40, T_RCD = 15, T_CAS = 15, T_CAC = 15;
  localparam int T_CSR = 5, T_CHR = 10, T_REFI = 15600;

  function automatic int cy(input int ns);
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  localparam int EXP_LAT = 2 + cy(T_RCD) + mx(mx(cy(T_CAS), cy(T_CAC) + 1), cy(T_RAS) - cy(T_RCD) - 1);
  localparam int REFI_CYC = cy(T_REFI);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_side = 0;
  logic [3:0] req_lanes = 0;
  logic [9:0] req_row = 0, req_col = 0;
  logic [35:0] req_wdata = 0;
  logic req_ready, rsp_done, dram_we_n, dram_dq_oe;
  logic [35:0] rsp_rdata, dram_dq_out, dram_dq_in;
  logic [9:0] dram_addr;
  logic [3:0] dram_ras_n, dram_cas_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpm_dram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_side(req_side), .req_lanes(req_lanes),
    .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  int vectors = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  localparam logic [35:0] GARBAGE = 36'h5_A5A5_A5A5;
  function automatic logic [35:0] init_val(input int key);
    logic [31:0] h;
    h = key * 32'h9E37_79B1;
    return {key[3:0], h};
  endfunction
  function automatic logic [35:0] expand(input logic [3:0] m);
    logic [35:0] r;
    for (int i = 0; i < 4; i++) r[i*9 +: 9] = {9{m[i]}};
    return r;
  endfunction

  logic [35:0] mdl_mem [int];
  logic [35:0] ref_mem [int];
  logic cur_side = 0;

  // behavioural module model with timing checks, sampling on falling edges
  logic [3:0] p_ras = 4'hF, p_cas = 4'hF;
  logic p_we = 1;
  int ras_hi = 100, ras_lo = 0, cas_lo = 0, since_ras = 0, since_fall = 100;
  int ref_gap = 0, ref_cnt = 0, total_cyc = 0;
  logic m_side = 0;
  logic [9:0] m_row = 0;
  int m_key = 0;
  time cas_t = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras = 4'hF; p_cas = 4'hF; p_we = 1; ras_hi = 100; ref_gap = 0; dram_dq_in = GARBAGE;
    end else begin
      total_cyc++; ref_gap++;
      if (p_ras == 4'hF && dram_ras_n != 4'hF) begin
        chk(ras_hi * CLK_PERIOD >= T_RP, "R7 row precharge", ras_hi, cy(T_RP));
        chk(since_fall * CLK_PERIOD >= T_RC, "R7 random cycle", since_fall, cy(T_RC));
        if (dram_ras_n == 4'h0) begin
          chk(p_cas == 4'h0, "R8 column strobes before row", p_cas, 0);
          chk(dram_we_n, "R8 write enable high in refresh", dram_we_n, 1);
          chk(ref_gap <= REFI_CYC + 16, "R9 R10 refresh interval", ref_gap, REFI_CYC);
          ref_gap = 0; ref_cnt++;
        end else begin
          chk(dram_ras_n == (cur_side ? 4'b0101 : 4'b1010), "R3 side pair", dram_ras_n,
              cur_side ? 4'b0101 : 4'b1010);
          m_side = (dram_ras_n == 4'b0101); m_row = dram_addr;
        end
        since_ras = 0; since_fall = 0; ras_lo = 0;
      end
      if (p_ras != 4'hF && dram_ras_n == 4'hF) begin
        chk(ras_lo * CLK_PERIOD >= T_RAS, "R7 row low", ras_lo, cy(T_RAS));
        ras_hi = 0;
      end
      if (dram_ras_n == 4'h0 && p_ras == 4'h0 && p_cas == 4'h0 && dram_cas_n != 4'h0)
        chk(ras_lo * CLK_PERIOD >= T_CHR, "R8 column hold", ras_lo, cy(T_CHR));
      if (p_cas == 4'hF && dram_cas_n != 4'hF && dram_ras_n != 4'h0 && dram_ras_n != 4'hF) begin
        chk(since_ras * CLK_PERIOD >= T_RCD, "R7 row to column", since_ras, cy(T_RCD));
        m_key = {m_side, m_row, dram_addr};
        if (!mdl_mem.exists(m_key)) mdl_mem[m_key] = init_val(m_key);
        if (!dram_we_n) begin
          chk(!p_we, "R5 early write setup", p_we, 0);
          chk(dram_dq_oe, "R5 drive during write", dram_dq_oe, 1);
          mdl_mem[m_key] = (mdl_mem[m_key] & ~expand(~dram_cas_n)) | (dram_dq_out & expand(~dram_cas_n));
        end else begin
          chk(!dram_dq_oe && p_we, "R6 read enables", {dram_dq_oe, p_we}, 2'b01);
          cas_t = $time - CLK_PERIOD/2;
        end
        cas_lo = 0;
      end
      if (p_cas != 4'hF && dram_cas_n != 4'hF && dram_ras_n != 4'h0 && p_ras != 4'h0)
        chk(dram_we_n == p_we, "R5 R6 write enable stable", dram_we_n, p_we);
      if (p_cas != 4'hF && dram_cas_n == 4'hF && p_ras != 4'h0)
        chk(cas_lo * CLK_PERIOD >= T_CAS, "R7 column low", cas_lo, cy(T_CAS));
      if (dram_cas_n != 4'hF && dram_we_n && dram_ras_n != 4'h0 && ($time - cas_t) >= T_CAC)
        dram_dq_in = (mdl_mem[m_key] & expand(~dram_cas_n)) | (GARBAGE & ~expand(~dram_cas_n));
      else dram_dq_in = GARBAGE;
      if (dram_ras_n == 4'hF) ras_hi++; else begin ras_lo++; since_ras++; end
      if (dram_cas_n != 4'hF) cas_lo++;
      since_fall++;
      p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n;
    end
  end

  task automatic access(input bit wr, input bit side, input logic [3:0] lanes,
                        input logic [9:0] row, input logic [9:0] col, input logic [35:0] wd);
    int key, lat;
    logic [35:0] exp;
    key = {side, row, col};
    if (!ref_mem.exists(key)) ref_mem[key] = init_val(key);
    req_valid = 1; req_write = wr; req_side = side; req_lanes = lanes;
    req_row = row; req_col = col; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    cur_side = side;
    @(negedge clk);
    req_valid = 0;
    lat = 0;
    while (!rsp_done && lat < 50) begin @(negedge clk); lat++; end
    chk(lat == EXP_LAT, "R11 done latency", lat, EXP_LAT);
    if (wr) ref_mem[key] = (ref_mem[key] & ~expand(lanes)) | (wd & expand(lanes));
    else begin
      exp = ref_mem[key] & expand(lanes);
      chk(rsp_rdata == exp, "R2 R4 R6 read data", rsp_rdata, exp);
    end
    @(negedge clk);
    chk(!rsp_done, "R11 single pulse", rsp_done, 0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(dram_ras_n == 4'hF && dram_cas_n == 4'hF && dram_we_n && !rsp_done && !dram_dq_oe,
        "R1 reset outputs", {dram_ras_n, dram_cas_n, dram_we_n, rsp_done, dram_dq_oe}, 11'h7FC);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && dram_ras_n == 4'hF && dram_cas_n == 4'hF, "R1 ready after reset",
        {req_ready, dram_ras_n, dram_cas_n}, 9'h1FF);
    access(1, 0, 4'hF, 10'd0, 10'd0, 36'h1_2345_6789);
    access(0, 0, 4'hF, 10'd0, 10'd0, 0);
    access(1, 1, 4'hF, 10'd0, 10'd0, 36'hF_EDCB_A987);
    access(0, 0, 4'hF, 10'd0, 10'd0, 0);
    access(0, 1, 4'hF, 10'd0, 10'd0, 0);
    access(1, 0, 4'b0001, 10'd1023, 10'd1023, 36'h0_0000_01FF);
    access(1, 0, 4'b1000, 10'd1023, 10'd1023, 36'hF_F800_0000);
    access(0, 0, 4'hF, 10'd1023, 10'd1023, 0);
    access(0, 0, 4'b0110, 10'd1023, 10'd1023, 0);
    access(0, 1, 4'hF, 10'd1023, 10'd0, 0);
    for (int n = 0; n < 600; n++) begin
      logic [3:0] m;
      m = 4'($urandom_range(1, 15));
      access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), m,
             10'($urandom_range(0, 7)) | (($urandom_range(0, 3) == 0) ? 10'h3F8 : 10'h0),
             10'($urandom_range(0, 7)), {4'($urandom), 32'($urandom)});
    end
    repeat (4000) @(negedge clk);
    chk(ref_cnt >= total_cyc / REFI_CYC - 1, "R9 refresh count", ref_cnt, total_cyc / REFI_CYC);
    for (int n = 0; n < 20; n++) access(0, 1'(n & 1), 4'hF, 10'($urandom_range(0, 7)), 10'($urandom_range(0, 7)), 0);
    summary();
  end
endmodule